// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide parallel NOR flash device. It watches an asynchronous-style memory bus: active-low select, write strobe and read strobe, a 20-bit address and an 8-bit bidirectional data bus. The bus pins are sampled on the system clock. Each write cycle is captured as an address and data pair. A decoder walks those pairs through unlock-plus-command sequences. When a sequence completes, the decoder launches a byte program or a sector erase on an internal job sequencer.

While a job runs, the ready output is low. Reads then return a status byte instead of array data. In that byte, bit 7 is a completion poll and bit 6 changes after every read. A running program locks out every command. A running sector erase accepts only a suspend. A suspended erase leaves the device readable and programmable outside the erasing sector, until a resume continues the erase. A small behavioural array stands in for the flash cells. It stores 16 bytes per 64 KB sector, selected by address bits 3:0, and aliases the rest of the address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rdy is 1 and a read of any address returns the array contents, which start at FFh.
- R2: A write cycle is the interval with bus_sel_n and bus_wr_n both low. Its address is taken at the clock edge where the interval begins. Its data is taken at the edge where the interval ends, whichever strobe rises first. Address changes later in the cycle and data values earlier in the cycle have no effect.
- R3: The writes 55h@555h, AAh@2AAh, A0h@555h, then D@A start a program. The unlock addresses compare only address bits 10:0. rdy is then low for exactly PROG_CYCLES clocks. Afterwards, the byte at index {A[19:16],A[3:0]} reads as its old value AND D.
- R4: A write whose data or address does not match the next expected step returns the decoder to idle, and no job starts.
- R5: While a program runs, every write is ignored. A complete second program sequence issued during the job leaves its target unchanged.
- R6: During a program, reads return status with bit 7 = NOT D[7] and bits 5:0 = 0. Bit 6 differs between two successive reads. Once rdy is back to 1, reads return array data.
- R7: The writes 55h@555h, AAh@2AAh, 80h@555h, 55h@555h, AAh@2AAh, then 30h@S start an erase of sector S[19:16]. rdy is low for ERASE_CYCLES clocks. During the erase, reads return bit 7 = 0, bits 5:0 = 0, and a toggling bit 6. Afterwards, every byte of that sector is FFh and other sectors are unchanged.
- R8: While an erase runs, only B0h (any address) is accepted. It suspends the erase: rdy returns to 1 and reads return array data. Other writes are ignored.
- R9: While suspended, a program outside the suspended sector runs normally, and one inside it is dropped without a job. 30h (any address) resumes the erase. The erase's low-rdy clocks before and after the suspend add up to ERASE_CYCLES.
- R10: Writing F0h at any step of a sequence returns the decoder to idle. Holding rst_n low also aborts any running job without changing the array, and leaves rdy at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; aborts sequences and jobs |
| bus_sel_n | input | 1 | Device select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe (output enable), active low |
| bus_addr | input | 20 | Byte address |
| bus_data | inout | 8 | Data bus; driven by the block during a read cycle |
| rdy | output | 1 | High when no job is running (including while an erase is suspended) |

## Verification
A decoder stuck in the wrong sequence step shows up at the ports one write later. The next valid command then fails to pull rdy low, or a broken sequence wrongly pulls it low, within three clocks of the end of the write. A corrupt job counter shows up as a low-rdy interval of the wrong length. A lost suspend context shows up as an erase total that does not equal ERASE_CYCLES, or as a sector that is not fully FFh on the read-back after rdy rises. The status multiplexer and the toggle register are exposed on the first and second reads made while rdy is low.

// File: rtl/flcmd_pkg.sv
// Shared constants and types for the flash command front end.
// Assumes unlock addresses are compared on the low UNLOCK_W address bits.
package flcmd_pkg;
    localparam int UNLOCK_W = 11;

    localparam logic [UNLOCK_W-1:0] UNL_ADDR_A = 11'h555;
    localparam logic [UNLOCK_W-1:0] UNL_ADDR_B = 11'h2AA;

    localparam logic [7:0] OP_UNL_A       = 8'h55;
    localparam logic [7:0] OP_UNL_B       = 8'hAA;
    localparam logic [7:0] OP_PROG        = 8'hA0;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h80;
    localparam logic [7:0] OP_ERASE_GO    = 8'h30;
    localparam logic [7:0] OP_RESUME      = 8'h30;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_ABORT       = 8'hF0;

    typedef enum logic [2:0] {
        D_IDLE,
        D_UNL1,
        D_UNL2,
        D_PDATA,
        D_EUNL0,
        D_EUNL1,
        D_EUNL2
    } dec_state_e;
endpackage

// File: rtl/bus_capture.sv
// Bus cycle capture: turns sampled strobe levels into one write pulse per
// write cycle and flags read activity.
// Assumes the bus pins are synchronous to clk; a write cycle spans the clocks
// with select and write strobe both low.
module bus_capture #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_active,
    output logic          rd_end
);
    logic wr_act;
    logic wr_q;
    logic rd_q;

    assign wr_act    = ~sel_n & ~wr_n;
    assign rd_active = ~sel_n & ~rd_n & wr_n;
    assign rd_end    = rd_q & ~rd_active;

    // Track strobe history; latch address at cycle start, data at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_active;
            if (wr_act && !wr_q) begin
                wr_addr <= addr;
            end
            if (!wr_act && wr_q) begin
                wr_pulse <= 1'b1;
                wr_data  <= din;
            end else begin
                wr_pulse <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmd_decoder.sv
// Command decoder: walks captured writes through the unlock and command
// sequences and issues single-cycle job requests.
// Assumes busy flags come from the job sequencer; a running program blocks
// every write, a running erase only listens for suspend.
module cmd_decoder
    import flcmd_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int SEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pulse,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             prog_busy,
    input  logic             erase_run,
    input  logic             erase_susp,
    input  logic [SEC_W-1:0] susp_sector,
    output logic             start_prog,
    output logic             start_erase,
    output logic             suspend_req,
    output logic             resume_req,
    output logic [AW-1:0]    job_addr,
    output logic [DW-1:0]    job_data
);
    dec_state_e state;
    logic       hit_a;
    logic       hit_b;
    logic       in_susp_sector;
    logic [7:0] op;

    assign op             = wr_data[7:0];
    assign hit_a          = (wr_addr[UNLOCK_W-1:0] == UNL_ADDR_A);
    assign hit_b          = (wr_addr[UNLOCK_W-1:0] == UNL_ADDR_B);
    assign in_susp_sector = erase_susp && (wr_addr[AW-1 -: SEC_W] == susp_sector);

    // Sequence state machine and registered job requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= D_IDLE;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
            job_addr    <= '0;
            job_data    <= '0;
        end else begin
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
            if (wr_pulse) begin
                if (prog_busy) begin
                    state <= state;
                end else if (erase_run) begin
                    if (op == OP_SUSPEND) begin
                        suspend_req <= 1'b1;
                    end
                end else if (op == OP_ABORT) begin
                    state <= D_IDLE;
                end else begin
                    unique case (state)
                        D_IDLE: begin
                            if (erase_susp && op == OP_RESUME) begin
                                resume_req <= 1'b1;
                            end else if (hit_a && op == OP_UNL_A) begin
                                state <= D_UNL1;
                            end
                        end
                        D_UNL1:  state <= (hit_b && op == OP_UNL_B) ? D_UNL2 : D_IDLE;
                        D_UNL2: begin
                            if (hit_a && op == OP_PROG) begin
                                state <= D_PDATA;
                            end else if (hit_a && op == OP_ERASE_SETUP && !erase_susp) begin
                                state <= D_EUNL0;
                            end else begin
                                state <= D_IDLE;
                            end
                        end
                        D_PDATA: begin
                            if (!in_susp_sector) begin
                                start_prog <= 1'b1;
                                job_addr   <= wr_addr;
                                job_data   <= wr_data;
                            end
                            state <= D_IDLE;
                        end
                        D_EUNL0: state <= (hit_a && op == OP_UNL_A) ? D_EUNL1 : D_IDLE;
                        D_EUNL1: state <= (hit_b && op == OP_UNL_B) ? D_EUNL2 : D_IDLE;
                        D_EUNL2: begin
                            if (op == OP_ERASE_GO) begin
                                start_erase <= 1'b1;
                                job_addr    <= wr_addr;
                            end
                            state <= D_IDLE;
                        end
                        default: state <= D_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/job_sequencer.sv
// Job sequencer: times program and sector erase jobs with down counters,
// holds the paused erase while suspended, and raises one-cycle commit
// strobes on the final clock of each job.
// Assumes a program may start while an erase is suspended, never while one runs.
module job_sequencer #(
    parameter int AW           = 20,
    parameter int DW           = 8,
    parameter int SEC_W        = 4,
    parameter int PROG_CYCLES  = 24,
    parameter int ERASE_CYCLES = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic [AW-1:0]    job_addr,
    input  logic [DW-1:0]    job_data,
    output logic             prog_busy,
    output logic             prog_done,
    output logic [AW-1:0]    prog_addr,
    output logic [DW-1:0]    prog_data,
    output logic             erase_run,
    output logic             erase_susp,
    output logic             erase_done,
    output logic [SEC_W-1:0] erase_sector
);
    localparam int PCW = (PROG_CYCLES  > 1) ? $clog2(PROG_CYCLES)  : 1;
    localparam int ECW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;

    logic [PCW-1:0] pcnt;
    logic [ECW-1:0] ecnt;
    logic           erase_busy;

    assign prog_done  = prog_busy && (pcnt == '0);
    assign erase_run  = erase_busy && !erase_susp;
    assign erase_done = erase_run && (ecnt == '0);

    // Program job timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_busy <= 1'b0;
            pcnt      <= '0;
            prog_addr <= '0;
            prog_data <= '0;
        end else if (prog_busy) begin
            if (pcnt == '0) begin
                prog_busy <= 1'b0;
            end else begin
                pcnt <= pcnt - 1'b1;
            end
        end else if (start_prog) begin
            prog_busy <= 1'b1;
            pcnt      <= PCW'(PROG_CYCLES - 1);
            prog_addr <= job_addr;
            prog_data <= job_data;
        end
    end

    // Erase job timer with suspend and resume; a suspend still counts its clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_busy   <= 1'b0;
            erase_susp   <= 1'b0;
            ecnt         <= '0;
            erase_sector <= '0;
        end else if (erase_busy) begin
            if (erase_susp) begin
                if (resume_req) begin
                    erase_susp <= 1'b0;
                end
            end else if (ecnt == '0) begin
                erase_busy <= 1'b0;
            end else begin
                ecnt <= ecnt - 1'b1;
                if (suspend_req) begin
                    erase_susp <= 1'b1;
                end
            end
        end else if (start_erase) begin
            erase_busy   <= 1'b1;
            ecnt         <= ECW'(ERASE_CYCLES - 1);
            erase_sector <= job_addr[AW-1 -: SEC_W];
        end
    end
endmodule

// File: rtl/flash_array_model.sv
// Behavioural stand-in for the flash cells: 2**LOW_W bytes per sector,
// indexed by {sector bits, low address bits}; other address bits alias.
// Programming can only clear bits; erase sets a whole sector to all ones.
// Assumes contents survive reset and start erased.
module flash_array_model #(
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int SEC_W = 4,
    parameter int LOW_W = 4
) (
    input  logic             clk,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             prog_we,
    input  logic [AW-1:0]    prog_addr,
    input  logic [DW-1:0]    prog_data,
    input  logic             erase_we,
    input  logic [SEC_W-1:0] erase_sector
);
    localparam int IDX_W = SEC_W + LOW_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];
    logic [IDX_W-1:0] prog_idx;
    logic [IDX_W-1:0] rd_idx;
    wire unused_addr_bits = ^{rd_addr[AW-SEC_W-1:LOW_W], prog_addr[AW-SEC_W-1:LOW_W]};

    assign prog_idx = {prog_addr[AW-1 -: SEC_W], prog_addr[LOW_W-1:0]};
    assign rd_idx   = {rd_addr[AW-1 -: SEC_W], rd_addr[LOW_W-1:0]};
    assign rd_data  = mem[rd_idx];

    // Start from the erased state.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    end

    // Apply sector erase or AND-programming on a commit strobe.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_we && (i[IDX_W-1:LOW_W] == erase_sector)) begin
                mem[i] <= '1;
            end else if (prog_we && (i[IDX_W-1:0] == prog_idx)) begin
                mem[i] <= mem[i] & prog_data;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command front end: bus capture, command decoder, job
// sequencer and array model, plus the read multiplexer that returns a status
// byte (bit 7 poll, bit 6 toggle) while a job runs.
// Assumes DW >= 8 and AW >= 11; bus pins are synchronous to clk.
module flash_cmd_ctrl #(
    parameter int AW           = 20,
    parameter int DW           = 8,
    parameter int SEC_W        = 4,
    parameter int LOW_W        = 4,
    parameter int PROG_CYCLES  = 24,
    parameter int ERASE_CYCLES = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_n,
    input  logic          bus_wr_n,
    input  logic          bus_rd_n,
    input  logic [AW-1:0] bus_addr,
    inout  wire  [DW-1:0] bus_data,
    output logic          rdy
);
    logic             wr_pulse;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    wr_data;
    logic             rd_active;
    logic             rd_end;
    logic             start_prog;
    logic             start_erase;
    logic             suspend_req;
    logic             resume_req;
    logic [AW-1:0]    job_addr;
    logic [DW-1:0]    job_data;
    logic             prog_busy;
    logic             prog_done;
    logic [AW-1:0]    prog_addr;
    logic [DW-1:0]    prog_data;
    logic             erase_run;
    logic             erase_susp;
    logic             erase_done;
    logic [SEC_W-1:0] erase_sector;
    logic [DW-1:0]    arr_data;
    logic [DW-1:0]    rd_mux;
    logic             tog;
    logic             job_active;

    bus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .sel_n(bus_sel_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n),
        .addr(bus_addr), .din(bus_data), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_active(rd_active), .rd_end(rd_end)
    );

    cmd_decoder #(.AW(AW), .DW(DW), .SEC_W(SEC_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_busy(prog_busy), .erase_run(erase_run), .erase_susp(erase_susp),
        .susp_sector(erase_sector), .start_prog(start_prog), .start_erase(start_erase),
        .suspend_req(suspend_req), .resume_req(resume_req), .job_addr(job_addr),
        .job_data(job_data)
    );

    job_sequencer #(
        .AW(AW), .DW(DW), .SEC_W(SEC_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .suspend_req(suspend_req), .resume_req(resume_req), .job_addr(job_addr),
        .job_data(job_data), .prog_busy(prog_busy), .prog_done(prog_done),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_run(erase_run),
        .erase_susp(erase_susp), .erase_done(erase_done), .erase_sector(erase_sector)
    );

    flash_array_model #(.AW(AW), .DW(DW), .SEC_W(SEC_W), .LOW_W(LOW_W)) u_arr (
        .clk(clk), .rd_addr(bus_addr), .rd_data(arr_data), .prog_we(prog_done),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_we(erase_done),
        .erase_sector(erase_sector)
    );

    assign job_active = prog_busy | erase_run;
    assign rdy        = ~job_active;

    // Toggle bit: inverts at the end of every read made while a job runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (job_active && rd_end) begin
            tog <= ~tog;
        end
    end

    // Read data source: status during a job, array otherwise.
    always_comb begin
        if (prog_busy) begin
            rd_mux = {~prog_data[DW-1], tog, {(DW-2){1'b0}}};
        end else if (erase_run) begin
            rd_mux = {1'b0, tog, {(DW-2){1'b0}}};
        end else begin
            rd_mux = arr_data;
        end
    end

    assign bus_data = rd_active ? rd_mux : {DW{1'bz}};
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Assertion checker for flash_cmd_ctrl, attached with bind below.
// Relates decoder requests, sequencer state, the toggle register and rdy.
module flash_cmd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_busy,
    input logic erase_run,
    input logic erase_susp,
    input logic erase_done,
    input logic start_prog,
    input logic start_erase,
    input logic suspend_req,
    input logic resume_req,
    input logic rd_end,
    input logic tog,
    input logic rdy
);
    AST_PROG_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !(start_prog || start_erase || suspend_req || resume_req)); // R5

    AST_ERASE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        erase_run |-> !(start_prog || start_erase || resume_req)); // R8

    AST_SUSPEND_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_req && erase_run && !erase_done) |=> erase_susp); // R8

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_busy || erase_run) && rd_end) |=> (tog != $past(tog))); // R6

    AST_PROG_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> $past(start_prog)); // R3

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rdy); // R10
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_run(erase_run),
    .erase_susp(erase_susp), .erase_done(erase_done), .start_prog(start_prog),
    .start_erase(start_erase), .suspend_req(suspend_req), .resume_req(resume_req),
    .rd_end(rd_end), .tog(tog), .rdy(rdy)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/100ps
module flash_cmd_ctrl_test;
    localparam int PROG_CYC  = 24;
    localparam int ERASE_CYC = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [19:0] addr = '0;
    logic        drv_en = 1'b0;
    logic [7:0]  drv_val = '0;
    wire  [7:0]  bus_data;
    wire         rdy;

    int checks = 0;
    int errors = 0;
    int lowcnt = 0;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    assign bus_data = drv_en ? drv_val : 8'hzz;

    flash_cmd_ctrl #(.PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
        .bus_addr(addr), .bus_data(bus_data), .rdy(rdy)
    );

    always @(negedge clk) if (rdy === 1'b0) lowcnt++;

    function automatic int idx(input logic [19:0] a);
        return int'({a[19:16], a[3:0]});
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; drv_val = d; drv_en = 1'b1; sel_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); sel_n = 1'b1; drv_en = 1'b0;
        @(negedge clk);
    endtask

    // Address and data change mid-cycle; cycle ends on the select strobe.
    task automatic bus_write_alt(input logic [19:0] a0, input logic [19:0] a1,
                                 input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk); addr = a0; drv_val = d0; drv_en = 1'b1; sel_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); addr = a1; drv_val = d1;
        @(negedge clk); sel_n = 1'b1;
        @(negedge clk); wr_n = 1'b1; drv_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [19:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; sel_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); v = bus_data; rd_n = 1'b1; sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_program(input logic [19:0] a, input logic [7:0] d);
        bus_write(20'h00555, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(20'h00555, 8'hA0);
        bus_write(a, d);
    endtask

    task automatic do_erase(input logic [19:0] a);
        bus_write(20'h00555, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(20'h00555, 8'h80);
        bus_write(20'h00555, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(a, 8'h30);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        @(negedge clk);
        while (rdy !== 1'b1 && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic erase_model(input logic [3:0] s);
        for (int k = 0; k < 16; k++) model[{s, k[3:0]}] = 8'hFF;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [7:0]  v2;
        logic [19:0] a;
        logic [7:0]  d;
        int          n;
        int          snap;
        int          seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int k = 0; k < 256; k++) model[k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rdy after reset", int'(rdy), 1);
        bus_read(20'h12345, v);
        chk("R1 erased read", int'(v), 8'hFF);

        // R3: directed program with busy length
        do_program(20'h12345, 8'h5A);
        wait_ready(n);
        chk("R3 program busy length", n, PROG_CYC);
        model[idx(20'h12345)] &= 8'h5A;
        bus_read(20'h12345, v);
        chk("R3 program result", int'(v), int'(model[idx(20'h12345)]));
        do_program(20'hA2345, 8'h0F);
        wait_ready(n);
        model[idx(20'hA2345)] &= 8'h0F;
        do_program(20'hA2345, 8'hF3);
        wait_ready(n);
        model[idx(20'hA2345)] &= 8'hF3;
        bus_read(20'hA2345, v);
        chk("R3 reprogram ANDs bits", int'(v), int'(model[idx(20'hA2345)]));

        // R6: status bytes during program
        do_program(20'h00007, 8'h3C);
        bus_read(20'h00007, v);
        bus_read(20'h00007, v2);
        chk("R6 poll bit is inverted data bit7", int'(v[7]), 1);
        chk("R6 low status bits zero", int'(v[5:0]), 0);
        chk("R6 toggle bit changes", int'(v[6] ^ v2[6]), 1);
        wait_ready(n);
        model[idx(20'h00007)] &= 8'h3C;
        bus_read(20'h00007, v);
        chk("R6 true data after completion", int'(v), int'(model[idx(20'h00007)]));
        do_program(20'h00008, 8'hC3);
        bus_read(20'h00008, v);
        chk("R6 poll bit for data bit7 set", int'(v[7]), 0);
        wait_ready(n);
        model[idx(20'h00008)] &= 8'hC3;

        // R5: full program sequence issued during a running program is ignored
        do_program(20'h20001, 8'h77);
        do_program(20'h20002, 8'h00);
        wait_ready(n);
        model[idx(20'h20001)] &= 8'h77;
        bus_read(20'h20002, v);
        chk("R5 locked-out program target", int'(v), int'(model[idx(20'h20002)]));
        bus_read(20'h20001, v);
        chk("R5 first program kept", int'(v), int'(model[idx(20'h20001)]));

        // R4: broken sequences start no job
        lowcnt = 0;
        bus_write(20'h00555, 8'h55);
        bus_write(20'h002AA, 8'hAB);
        bus_write(20'h00555, 8'hA0);
        bus_write(20'h30003, 8'h00);
        repeat (6) @(negedge clk);
        chk("R4 wrong data no job", lowcnt, 0);
        bus_write(20'h00556, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(20'h00555, 8'hA0);
        bus_write(20'h30003, 8'h00);
        repeat (6) @(negedge clk);
        chk("R4 wrong address no job", lowcnt, 0);
        bus_read(20'h30003, v);
        chk("R4 array unchanged", int'(v), int'(model[idx(20'h30003)]));

        // R2: address at cycle start, data at cycle end (select rises first)
        bus_write_alt(20'h00555, 20'h0F0F0, 8'h00, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(20'h00555, 8'hA0);
        bus_write_alt(20'h40009, 20'h50005, 8'hFF, 8'h81);
        wait_ready(n);
        chk("R2 late-changed step accepted", n, PROG_CYC);
        model[idx(20'h40009)] &= 8'h81;
        bus_read(20'h40009, v);
        chk("R2 captured address and data", int'(v), int'(model[idx(20'h40009)]));
        lowcnt = 0;
        bus_write_alt(20'h00123, 20'h00555, 8'h55, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(20'h00555, 8'hA0);
        bus_write(20'h40009, 8'h00);
        repeat (6) @(negedge clk);
        chk("R2 late address ignored", lowcnt, 0);

        // R10: abort code and reset
        lowcnt = 0;
        bus_write(20'h00555, 8'h55);
        bus_write(20'h002AA, 8'hAA);
        bus_write(20'h00555, 8'hF0);
        bus_write(20'h30004, 8'h00);
        repeat (6) @(negedge clk);
        chk("R10 abort code no job", lowcnt, 0);
        do_program(20'h30005, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 rdy after reset abort", int'(rdy), 1);
        bus_read(20'h30005, v);
        chk("R10 aborted program not written", int'(v), int'(model[idx(20'h30005)]));

        // R7: sector erase
        do_program(20'h30001, 8'h12); wait_ready(n); model[idx(20'h30001)] &= 8'h12;
        do_program(20'h3FFF2, 8'h34); wait_ready(n); model[idx(20'h3FFF2)] &= 8'h34;
        do_program(20'h40001, 8'h56); wait_ready(n); model[idx(20'h40001)] &= 8'h56;
        lowcnt = 0;
        do_erase(20'h3ABCD);
        bus_read(20'h30001, v);
        bus_read(20'h30001, v2);
        chk("R7 erase poll bit zero", int'(v[7]), 0);
        chk("R7 erase low status bits", int'(v[5:0]), 0);
        chk("R7 erase toggle changes", int'(v[6] ^ v2[6]), 1);
        wait_ready(n);
        chk("R7 erase busy length", lowcnt, ERASE_CYC);
        erase_model(4'h3);
        for (int k = 0; k < 16; k++) begin
            bus_read({4'h3, 12'h000, k[3:0]}, v);
            chk("R7 sector byte erased", int'(v), 8'hFF);
        end
        bus_read(20'h40001, v);
        chk("R7 other sector kept", int'(v), int'(model[idx(20'h40001)]));

        // R8 and R9: filter, suspend, program while suspended, resume
        do_program(20'h50003, 8'h11); wait_ready(n); model[idx(20'h50003)] &= 8'h11;
        lowcnt = 0;
        do_erase(20'h50000);
        do_program(20'h50003, 8'h00);
        bus_write(20'h00000, 8'hB0);
        @(negedge clk);
        chk("R8 rdy high after suspend", int'(rdy), 1);
        bus_read(20'h50003, v);
        chk("R8 suspended read is array data", int'(v), int'(model[idx(20'h50003)]));
        do_program(20'h60004, 8'h22);
        wait_ready(n);
        chk("R9 program during suspend busy length", n, PROG_CYC);
        model[idx(20'h60004)] &= 8'h22;
        bus_read(20'h60004, v);
        chk("R9 program during suspend result", int'(v), int'(model[idx(20'h60004)]));
        snap = lowcnt;
        do_program(20'h50007, 8'h00);
        repeat (6) @(negedge clk);
        chk("R9 program into suspended sector dropped", lowcnt, snap);
        bus_write(20'h00000, 8'h30);
        wait_ready(n);
        chk("R9 erase total after resume", lowcnt - PROG_CYC, ERASE_CYC);
        erase_model(4'h5);
        bus_read(20'h50003, v);
        chk("R9 suspended sector erased after resume", int'(v), 8'hFF);
        bus_read(20'h50007, v);
        chk("R8 ignored program during erase", int'(v), 8'hFF);
        bus_read(20'h60004, v);
        chk("R9 other sector kept", int'(v), int'(model[idx(20'h60004)]));

        // R3: constrained random programs and reads
        for (int it = 0; it < 40; it++) begin
            a = 20'($urandom);
            d = 8'($urandom);
            if (a[10:0] == 11'h555 || a[10:0] == 11'h2AA) a[0] = ~a[0];
            if (d == 8'hF0) d = 8'hF1;
            do_program(a, d);
            wait_ready(n);
            chk("R3 random busy length", n, PROG_CYC);
            model[idx(a)] &= d;
            bus_read(a, v);
            chk("R3 random program result", int'(v), int'(model[idx(a)]));
        end
        for (int it = 0; it < 20; it++) begin
            a = 20'($urandom);
            bus_read(a, v);
            chk("R1 random array read", int'(v), int'(model[idx(a)]));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule